// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control side of a multi-channel converter. It decides which analog input each conversion uses when a trigger arrives. It holds a table of channel-number slots and a per-channel enable mask, both supplied as parallel configuration inputs. A trigger starts one pass through the active slots. For each active slot the block raises one conversion request carrying the channel number and the slot index. It then waits for the converter's done pulse before it moves on. After the last active slot it reports the end of the pass.

Two orderings are offered. In programmed-order mode each slot supplies its own channel number. The same channel may appear in any number of slots and in any order. In scan mode the slot index itself is the channel, so the pass walks the enabled channels in ascending order. In both modes, slot k takes part only when enable bit k is set. A configuration check flags a programmed slot that names a channel whose enable bit is clear. A trigger that arrives while a pass is running is dropped, and a saturating counter records it. Configuration must be held steady while a pass runs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle: no request, `seq_busy_o` low, `seq_done_o` low, `ovr_count_o` zero.
- R2: A trigger sampled while idle, with at least one active slot, raises `seq_busy_o` and `conv_req_o` on the next cycle, on the lowest active slot.
- R3: Slot k is active exactly when `chan_en_i[k]` is 1. A pass visits every active slot once, in ascending slot order, and skips inactive slots.
- R4: With `user_mode_i` = 1, the request for slot k carries channel `slot_cfg_i[4*k +: 4]`. Repeated channel values are honoured.
- R5: With `user_mode_i` = 0, the request for slot k carries channel number k.
- R6: Only one request is outstanding. `conv_req_o`, `conv_slot_o` and `conv_chan_o` hold until `conv_done_i` is sampled high. The next active slot is presented on the following cycle.
- R7: `seq_done_o` is a one-cycle pulse in the cycle after the done for the last active slot is sampled. `seq_busy_o` is low in that cycle.
- R8: A trigger with no active slot produces a `seq_done_o` pulse on the next cycle and no request.
- R9: A trigger sampled while `seq_busy_o` is high starts nothing. It increments `ovr_count_o` by one on the next cycle, saturating at all ones.
- R10: `cfg_err_o` is 1 exactly when `user_mode_i` = 1 and some active slot holds a channel whose enable bit is 0. It responds combinationally and is always 0 in scan mode.
- R11: `conv_done_i` while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode_i | input | 1 | 1 = programmed slot order, 0 = ascending scan |
| chan_en_i | input | NUM_CH | Enable mask; bit k gates slot k |
| slot_cfg_i | input | NUM_CH*CH_W | Channel number of slot k in bits [CH_W*k +: CH_W] |
| trig_i | input | 1 | Start-of-pass trigger |
| conv_done_i | input | 1 | Converter completion pulse for the current request |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_chan_o | output | CH_W | Channel of the current request |
| conv_slot_o | output | CH_W | Slot index of the current request |
| seq_busy_o | output | 1 | Pass in progress |
| seq_done_o | output | 1 | One-cycle end-of-pass pulse |
| cfg_err_o | output | 1 | Active slot names a disabled channel |
| ovr_count_o | output | OVR_W | Saturating count of dropped triggers |

## Verification
A trigger can fall in the same cycle as the converter's final done. The block is still busy at that edge, so the trigger must be counted as an overrun and must not start a second pass. A trigger can also fall in the cycle where `seq_done_o` is high; since the block is idle there, that trigger must start a fresh pass. The bench's converter responder can issue a trigger together with every done pulse, and a separate step triggers while the done pulse is showing. A behavioural model decides acceptance from the busy state at each edge, and its busy, slot, done and counter values are compared with the outputs on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/adc_seq_pick.sv
// Finds the lowest set mask bit at or above a start index.
module adc_seq_pick #(
   parameter int N = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  mask_i,
   input  logic [IW:0]   from_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   logic [N-1:0] elig;

   generate
      for (genvar k = 0; k < N; k++) begin : g_elig
         assign elig[k] = mask_i[k] && (from_i <= (IW+1)'(k));
      end
   endgenerate

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (elig[k]) begin
            found_o = 1'b1;
            idx_o   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/adc_seq_cfg_check.sv
// Flags active slots that reference a disabled channel (programmed mode only).
module adc_seq_cfg_check #(
   parameter int N = 16,
   localparam int CW = $clog2(N)
) (
   input  logic          user_mode_i,
   input  logic [N-1:0]  chan_en_i,
   input  logic [N*CW-1:0] slot_cfg_i,
   output logic          err_o
);
   logic [N-1:0] bad;

   generate
      for (genvar k = 0; k < N; k++) begin : g_slot
         logic [CW-1:0] ch;
         assign ch     = slot_cfg_i[k*CW +: CW];
         assign bad[k] = chan_en_i[k] && !chan_en_i[ch];
      end
   endgenerate

   assign err_o = user_mode_i && (|bad);
endmodule

// File: rtl/adc_seq_ovr_cnt.sv
// Saturating counter of dropped triggers.
module adc_seq_ovr_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] count_o
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_o <= '0;
      else if (inc_i && count_o != MAXV)
         count_o <= count_o + 1'b1;
   end

   assert_ovr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && count_o != MAXV) |=> (count_o == $past(count_o) + 1'b1));

   assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i || count_o == MAXV) |=> $stable(count_o));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int OVR_W  = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   user_mode_i,
   input  logic [NUM_CH-1:0]      chan_en_i,
   input  logic [NUM_CH*CH_W-1:0] slot_cfg_i,
   input  logic                   trig_i,
   input  logic                   conv_done_i,
   output logic                   conv_req_o,
   output logic [CH_W-1:0]        conv_chan_o,
   output logic [CH_W-1:0]        conv_slot_o,
   output logic                   seq_busy_o,
   output logic                   seq_done_o,
   output logic                   cfg_err_o,
   output logic [OVR_W-1:0]       ovr_count_o
);
   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH)
         else $error("NUM_CH must be a power of two of at least 2");
      assert (OVR_W >= 1) else $error("OVR_W must be positive");
   end

   seq_state_e      state_q;
   logic [CH_W-1:0] cur_q;
   logic            done_q;
   logic [CH_W:0]   pick_from;
   logic            pick_found;
   logic [CH_W-1:0] pick_idx;

   // Search from slot 0 when idle, else from the slot after the current one.
   assign pick_from = (state_q == SEQ_IDLE) ? '0 : ({1'b0, cur_q} + 1'b1);

   adc_seq_pick #(.N(NUM_CH)) u_pick (
      .mask_i  (chan_en_i),
      .from_i  (pick_from),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   adc_seq_cfg_check #(.N(NUM_CH)) u_chk (
      .user_mode_i (user_mode_i),
      .chan_en_i   (chan_en_i),
      .slot_cfg_i  (slot_cfg_i),
      .err_o       (cfg_err_o)
   );

   adc_seq_ovr_cnt #(.W(OVR_W)) u_ovr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (trig_i && state_q == SEQ_RUN),
      .count_o (ovr_count_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cur_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (trig_i) begin
                  if (pick_found) begin
                     state_q <= SEQ_RUN;
                     cur_q   <= pick_idx;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            SEQ_RUN: begin
               if (conv_done_i) begin
                  if (pick_found) begin
                     cur_q <= pick_idx;
                  end else begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign seq_busy_o  = (state_q == SEQ_RUN);
   assign conv_req_o  = seq_busy_o;
   assign conv_slot_o = cur_q;
   assign seq_done_o  = done_q;

   // Channel source: programmed table or the slot index itself.
   assign conv_chan_o = user_mode_i ? slot_cfg_i[cur_q*CH_W +: CH_W] : cur_q;

   assert_req_on_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |-> chan_en_i[conv_slot_o]);

   assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy_o && conv_done_i) |=> (!seq_busy_o || conv_slot_o > $past(conv_slot_o)));

   assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy_o && !conv_done_i) |=> (seq_busy_o && $stable(conv_slot_o)));

   assert_start_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy_o) |-> $past(trig_i));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done_o |=> !seq_done_o);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done_o |-> !seq_busy_o);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_busy_o && !trig_i) |=> (!seq_busy_o && !seq_done_o));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int NCH  = 16;
   localparam int CW   = 4;
   localparam int OW   = 8;
   localparam int OMAX = 255;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            user_mode = 1'b0;
   logic [NCH-1:0]  chan_en = '0;
   logic [NCH*CW-1:0] slot_cfg = '0;
   logic            trig_man = 1'b0, trig_auto = 1'b0;
   logic            done_man = 1'b0, done_auto = 1'b0;
   logic            trig, cdone;
   logic            conv_req, seq_busy, seq_done, cfg_err;
   logic [CW-1:0]   conv_chan, conv_slot;
   logic [OW-1:0]   ovr_count;

   assign trig  = trig_man | trig_auto;
   assign cdone = done_man | done_auto;

   always #2.5 clk = ~clk;

   adc_seq_ctrl #(.NUM_CH(NCH), .OVR_W(OW)) uut (
      .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode), .chan_en_i(chan_en),
      .slot_cfg_i(slot_cfg), .trig_i(trig), .conv_done_i(cdone),
      .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_slot_o(conv_slot),
      .seq_busy_o(seq_busy), .seq_done_o(seq_done), .cfg_err_o(cfg_err),
      .ovr_count_o(ovr_count)
   );

   int compared = 0, mismatched = 0;
   string phase = "R1";

   // Behavioural reference state
   bit m_busy = 0, m_done = 0;
   int m_cur = 0, m_ovr = 0, req_seen = 0;

   function automatic int first_active(int from);
      for (int k = from; k < NCH; k++) if (chan_en[k]) return k;
      return -1;
   endfunction

   function automatic bit exp_err();
      if (!user_mode) return 0;
      for (int k = 0; k < NCH; k++)
         if (chan_en[k] && !chan_en[slot_cfg[k*CW +: CW]]) return 1;
      return 0;
   endfunction

   task automatic check(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit nd;
      int n;
      nd = 0;
      if (!rst_n) begin
         m_busy = 0; m_cur = 0; m_ovr = 0;
      end else if (!m_busy) begin
         if (trig) begin
            n = first_active(0);
            if (n < 0) nd = 1;
            else begin m_busy = 1; m_cur = n; end
         end
      end else begin
         if (trig && m_ovr < OMAX) m_ovr++;
         if (cdone) begin
            n = first_active(m_cur + 1);
            if (n < 0) begin m_busy = 0; nd = 1; end
            else m_cur = n;
         end
      end
      m_done = nd;
      #1;
      if (conv_req) req_seen++;
      check("R2 busy", seq_busy, m_busy);
      check("R6 req", conv_req, m_busy);
      check("R7 done", seq_done, m_done);
      check("R9 ovr", ovr_count, m_ovr);
      check("R10 err", cfg_err, exp_err());
      if (m_busy) begin
         check("R3 slot", conv_slot, m_cur);
         if (user_mode) check("R4 chan", conv_chan, slot_cfg[m_cur*CW +: CW]);
         else           check("R5 chan", conv_chan, m_cur);
      end
   end

   // Converter stand-in: answers after resp_lat waiting cycles.
   bit resp_en = 0, trig_on_done = 0;
   int resp_lat = 0, wait_cnt = 0;
   always @(negedge clk) begin
      done_auto = 0; trig_auto = 0;
      if (resp_en && conv_req) begin
         if (wait_cnt >= resp_lat) begin
            done_auto = 1; trig_auto = trig_on_done; wait_cnt = 0;
         end else wait_cnt++;
      end else wait_cnt = 0;
   end

   task automatic pulse_trig();
      @(negedge clk); trig_man = 1;
      @(negedge clk); trig_man = 0;
   endtask

   task automatic wait_pass();
      int n = 0;
      @(posedge clk); #1;
      while (!seq_done && n < 3000) begin @(posedge clk); #1; n++; end
      check("R7 pass ends", seq_done, 1);
   endtask

   task automatic set_slot(int k, int ch);
      slot_cfg[k*CW +: CW] = CW'(ch);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      phase = "R1";
      check("R1 req", conv_req, 0);
      check("R1 busy", seq_busy, 0);
      check("R1 ovr", ovr_count, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // Scan mode, all channels, immediate converter
      phase = "R5 full scan"; chan_en = 16'hFFFF; resp_en = 1; resp_lat = 0;
      pulse_trig(); wait_pass();

      // Scan mode, sparse mask, slow converter
      phase = "R3 sparse"; chan_en = 16'h8421; resp_lat = 2;
      pulse_trig(); wait_pass();

      // Programmed order, 15 active slots, repeats; slot 15 names disabled ch 15
      phase = "R4 user"; user_mode = 1; chan_en = 16'h7FFF; resp_lat = 1;
      set_slot(0,3); set_slot(1,3); set_slot(2,0); set_slot(3,7);
      set_slot(4,7); set_slot(5,7); set_slot(6,1); set_slot(7,14);
      set_slot(8,2); set_slot(9,2); set_slot(10,5); set_slot(11,9);
      set_slot(12,11); set_slot(13,0); set_slot(14,6); set_slot(15,15);
      @(negedge clk); @(negedge clk);
      check("R10 inactive slot ignored", cfg_err, 0);
      pulse_trig(); wait_pass();

      // Active slot naming a disabled channel
      phase = "R10 cfg err"; set_slot(2, 15);
      @(negedge clk); #1;
      check("R10 flagged", cfg_err, 1);
      user_mode = 0; #1;
      check("R10 scan clear", cfg_err, 0);
      user_mode = 1; set_slot(2, 0);

      // Empty active set
      phase = "R8 empty"; chan_en = '0; req_seen = 0;
      pulse_trig();
      @(posedge clk); #2;
      check("R8 no request", req_seen, 0);
      @(negedge clk);

      // Done while idle
      phase = "R11 idle done"; chan_en = 16'h00F0; resp_en = 0;
      @(negedge clk); done_man = 1; @(negedge clk); done_man = 0;
      repeat (3) @(negedge clk);
      check("R11 still idle", seq_busy, 0);

      // Trigger coinciding with every converter done, incl. the last
      phase = "R9 trig on done"; resp_en = 1; trig_on_done = 1; resp_lat = 1;
      pulse_trig(); wait_pass();
      trig_on_done = 0;
      check("R9 four dropped", ovr_count, 4);

      // Trigger in the cycle where the done pulse shows: accepted
      phase = "R2 trig on done pulse"; user_mode = 0; resp_lat = 0;
      pulse_trig();
      begin
         int n = 0;
         while (!seq_done && n < 500) begin @(negedge clk); n++; end
      end
      trig_man = 1; @(negedge clk); trig_man = 0;
      #1; check("R2 restarted", seq_busy, 1);
      wait_pass();

      // Overrun saturation
      phase = "R9 saturate"; chan_en = 16'h0001; resp_lat = 600;
      @(negedge clk); trig_man = 1;
      repeat (300) @(negedge clk);
      trig_man = 0;
      wait_pass();
      check("R9 saturated", ovr_count, OMAX);

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule